// File: doc/BRIEF.md
# Supply-Loss Write-Protect Supervisor

This block sits beside a battery-backed static memory and decides, from a sampled supply-voltage code, whether the host may use the memory. The supply code is unsigned, at 10 mV per LSB. While the supply is healthy the block grants access. When the supply sags it blocks writes and parks the data outputs in high impedance. When the supply keeps falling it switches the backup cell onto the array, and it hands the array back to the external supply as the rail returns. A tolerance-select input picks one of two threshold sets: a narrow-tolerance part and a wide-tolerance part.

A freshly reset block is sealed. The backup cell stays disconnected until the supply has once exceeded 4.25 V, and that release lasts until the next reset. After the supply returns, access stays blocked for a timed recovery interval. During that interval the host chip-enable (active low) must be held inactive the whole time. The length of the interval in clock cycles comes from the clock frequency and the recovery time in microseconds. All thresholds carry 2 LSB of hysteresis, so a sample dithering at a boundary cannot make the state flap.

Top module: `supply_guard`

## Requirements
- R1: With `tol_sel_wide`=0, a supply code at or below 452 in NORMAL or RECOVERY moves the block to PROTECTED. Leaving PROTECTED for RECOVERY needs a code at or above 477.
- R2: With `tol_sel_wide`=1, the fall trip is a code at or below 427 and the rise level is a code at or above 452.
- R3: In every state other than NORMAL, `access_enable`=0, `write_protect`=1 and `outputs_tristate`=1, whatever `ce_n` does. In NORMAL, `access_enable`=1, `write_protect`=0 and `outputs_tristate` follows `ce_n` with no clock delay.
- R4: PROTECTED moves to BATTERY when the code is at or below 298. BATTERY moves back to PROTECTED when the code is at or above 302. `battery_connect` is 1 only in BATTERY.
- R5: Reset gives SEALED with `seal_released`=0 and `battery_connect`=0. SEALED is left, for PROTECTED, only when the code exceeds 425. That same edge sets `seal_released`, so the battery can never connect while sealed.
- R6: Once set, `seal_released` stays 1 until reset, through every supply level.
- R7: RECOVERY moves to NORMAL only after REC_CYCLES = CLK_KHZ*RECOVERY_US/1000 consecutive clock edges in RECOVERY with `ce_n`=1. An edge with `ce_n`=0 restarts the count.
- R8: A fall trip during RECOVERY returns the block to PROTECTED at once. The recovery count then starts over from zero on the next entry to RECOVERY.
- R9: Every transition takes effect on the first rising edge that samples its condition, and the state moves at most one step per edge. `state` encodes SEALED=0, NORMAL=1, PROTECTED=2, BATTERY=3, RECOVERY=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supply_code | input | CODE_W (10) | Sampled supply voltage, 10 mV per LSB |
| tol_sel_wide | input | 1 | 0 selects the narrow-tolerance thresholds, 1 the wide-tolerance thresholds |
| ce_n | input | 1 | Host chip-enable, active low |
| access_enable | output | 1 | Host access to the memory allowed |
| write_protect | output | 1 | Writes blocked and bus inputs ignored |
| outputs_tristate | output | 1 | Memory data outputs held at high impedance |
| battery_connect | output | 1 | Backup cell switched onto the array |
| seal_released | output | 1 | Shipping seal has been released |
| state | output | 3 | Current supervisor state |

## Verification
Every output apart from the `ce_n` path of `outputs_tristate` comes straight from the state register. Each result is therefore due one rising edge after the inputs that cause it. The bench changes inputs on the falling edge, advances one rising edge and samples on the next falling edge. The `ce_n` path to `outputs_tristate` has no register, so it is sampled 1 ns after `ce_n` changes. Recovery is checked at both ends of the window. After REC_CYCLES-1 qualifying edges access must still be off, and the very next edge must turn it on. This is repeated after an entry, after a `ce_n` pulse and after an aborted recovery.

// File: rtl/supply_guard_pkg.sv
package supply_guard_pkg;

    typedef enum logic [2:0] {
        ST_SEALED = 3'd0,
        ST_NORMAL = 3'd1,
        ST_PROT   = 3'd2,
        ST_BATT   = 3'd3,
        ST_RECOV  = 3'd4
    } sg_state_e;

    typedef struct packed {
        sg_state_e state;
        logic      seal;
    } sg_regs_s;

endpackage

// File: rtl/sg_window.sv
// Two-sided level compare: one trip point for falling, one for rising.
module sg_window #(
    parameter int CODE_W = 10
) (
    input  logic [CODE_W-1:0] code,
    input  logic [CODE_W-1:0] lo_thr,
    input  logic [CODE_W-1:0] hi_thr,
    output logic              at_or_below,
    output logic              at_or_above
);
    assign at_or_below = (code <= lo_thr);
    assign at_or_above = (code >= hi_thr);
endmodule

// File: rtl/sg_recovery_timer.sv
// Counts consecutive qualifying cycles; done flags the last one.
module sg_recovery_timer #(
    parameter int CYCLES = 400000,
    localparam int CNT_W = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign done = run && (cnt_q == CNT_W'(CYCLES - 1));

    always_comb begin
        cnt_d = '0;
        if (run && !done) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/supply_guard.sv
module supply_guard
    import supply_guard_pkg::*;
#(
    parameter int CODE_W      = 10,
    parameter int CLK_KHZ     = 200000,
    parameter int RECOVERY_US = 2000,
    parameter int FULL_NARROW = 475,
    parameter int PROT_NARROW = 450,
    parameter int FULL_WIDE   = 450,
    parameter int PROT_WIDE   = 425,
    parameter int BATT_LVL    = 300,
    parameter int SEAL_LVL    = 425,
    parameter int HYST        = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] supply_code,
    input  logic              tol_sel_wide,
    input  logic              ce_n,
    output logic              access_enable,
    output logic              write_protect,
    output logic              outputs_tristate,
    output logic              battery_connect,
    output logic              seal_released,
    output logic [2:0]        state
);
    localparam int REC_RAW    = (CLK_KHZ * RECOVERY_US) / 1000;
    localparam int REC_CYCLES = (REC_RAW < 1) ? 1 : REC_RAW;

    localparam logic [CODE_W-1:0] TRIP_NARROW = CODE_W'(PROT_NARROW + HYST);
    localparam logic [CODE_W-1:0] TRIP_WIDE   = CODE_W'(PROT_WIDE + HYST);
    localparam logic [CODE_W-1:0] RISE_NARROW = CODE_W'(FULL_NARROW + HYST);
    localparam logic [CODE_W-1:0] RISE_WIDE   = CODE_W'(FULL_WIDE + HYST);
    localparam logic [CODE_W-1:0] BATT_ON     = CODE_W'(BATT_LVL - HYST);
    localparam logic [CODE_W-1:0] BATT_OFF    = CODE_W'(BATT_LVL + HYST);
    localparam logic [CODE_W-1:0] SEAL_CODE   = CODE_W'(SEAL_LVL);

    sg_regs_s regs_d, regs_q;

    logic [CODE_W-1:0] trip_lvl, rise_lvl;
    logic              fall_trip, rise_ok, batt_low, batt_ok;
    logic              seal_hit, rec_run, rec_done;

    assign trip_lvl = tol_sel_wide ? TRIP_WIDE : TRIP_NARROW;
    assign rise_lvl = tol_sel_wide ? RISE_WIDE : RISE_NARROW;
    assign seal_hit = (supply_code > SEAL_CODE);

    sg_window #(.CODE_W(CODE_W)) u_prot_win (
        .code        (supply_code),
        .lo_thr      (trip_lvl),
        .hi_thr      (rise_lvl),
        .at_or_below (fall_trip),
        .at_or_above (rise_ok)
    );

    sg_window #(.CODE_W(CODE_W)) u_batt_win (
        .code        (supply_code),
        .lo_thr      (BATT_ON),
        .hi_thr      (BATT_OFF),
        .at_or_below (batt_low),
        .at_or_above (batt_ok)
    );

    assign rec_run = (regs_q.state == ST_RECOV) && ce_n;

    sg_recovery_timer #(.CYCLES(REC_CYCLES)) u_rec_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (rec_run),
        .done  (rec_done)
    );

    always_comb begin
        regs_d = regs_q;
        case (regs_q.state)
            ST_SEALED: begin
                if (seal_hit) begin
                    regs_d.state = ST_PROT;
                    regs_d.seal  = 1'b1;
                end
            end
            ST_PROT: begin
                if (batt_low) begin
                    regs_d.state = ST_BATT;
                end else if (rise_ok) begin
                    regs_d.state = ST_RECOV;
                end
            end
            ST_BATT: begin
                if (batt_ok) begin
                    regs_d.state = ST_PROT;
                end
            end
            ST_RECOV: begin
                if (fall_trip) begin
                    regs_d.state = ST_PROT;
                end else if (rec_done) begin
                    regs_d.state = ST_NORMAL;
                end
            end
            ST_NORMAL: begin
                if (fall_trip) begin
                    regs_d.state = ST_PROT;
                end
            end
            default: regs_d.state = ST_PROT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{state: ST_SEALED, seal: 1'b0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign access_enable    = (regs_q.state == ST_NORMAL);
    assign write_protect    = (regs_q.state != ST_NORMAL);
    assign outputs_tristate = (regs_q.state != ST_NORMAL) || ce_n;
    assign battery_connect  = (regs_q.state == ST_BATT);
    assign seal_released    = regs_q.seal;
    assign state            = regs_q.state;
endmodule

// File: rtl/supply_guard_chk.sv
module supply_guard_chk #(
    parameter int CODE_W      = 10,
    parameter int CLK_KHZ     = 200000,
    parameter int RECOVERY_US = 2000,
    parameter int PROT_NARROW = 450,
    parameter int PROT_WIDE   = 425,
    parameter int HYST        = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] supply_code,
    input logic              tol_sel_wide,
    input logic              ce_n,
    input logic              access_enable,
    input logic              write_protect,
    input logic              outputs_tristate,
    input logic              battery_connect,
    input logic              seal_released,
    input logic [2:0]        state
);
    localparam int REC_RAW = (CLK_KHZ * RECOVERY_US) / 1000;
    localparam int REC_MIN = (REC_RAW < 1) ? 1 : REC_RAW;

    logic [CODE_W-1:0] trip_ref;
    int unsigned       run_cnt;

    assign trip_ref = tol_sel_wide ? CODE_W'(PROT_WIDE + HYST) : CODE_W'(PROT_NARROW + HYST);

    // consecutive edges spent in recovery with the host deselected
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= 0;
        end else if (state == 3'd4 && ce_n) begin
            if (run_cnt < 32'hFFFF_FFFF) run_cnt <= run_cnt + 1;
        end else begin
            run_cnt <= 0;
        end
    end

    a_r1_fall_protects: assert property (@(posedge clk) disable iff (!rst_n)
        (access_enable && supply_code <= trip_ref) |=> write_protect);

    a_r3_protect_tristate: assert property (@(posedge clk) disable iff (!rst_n)
        write_protect |-> (outputs_tristate && !access_enable));

    a_r4_battery_from_protect: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(battery_connect) |-> ($past(state) == 3'd2));

    a_r5_battery_needs_seal: assert property (@(posedge clk) disable iff (!rst_n)
        battery_connect |-> seal_released);

    a_r6_seal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        seal_released |=> seal_released);

    a_r7_no_early_access: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(access_enable) |-> (run_cnt >= REC_MIN));
endmodule

bind supply_guard supply_guard_chk #(
    .CODE_W      (CODE_W),
    .CLK_KHZ     (CLK_KHZ),
    .RECOVERY_US (RECOVERY_US),
    .PROT_NARROW (PROT_NARROW),
    .PROT_WIDE   (PROT_WIDE),
    .HYST        (HYST)
) u_sg_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .supply_code      (supply_code),
    .tol_sel_wide     (tol_sel_wide),
    .ce_n             (ce_n),
    .access_enable    (access_enable),
    .write_protect    (write_protect),
    .outputs_tristate (outputs_tristate),
    .battery_connect  (battery_connect),
    .seal_released    (seal_released),
    .state            (state)
);

// File: tb/test_supply_guard.sv
`timescale 1ns/1ps
module test_supply_guard;
    localparam int REC = 200;   // 200000 kHz * 1 us / 1000

    logic       clk = 1'b0;
    logic       rst_n;
    logic [9:0] supply_code;
    logic       tol_sel_wide;
    logic       ce_n;
    logic       access_enable, write_protect, outputs_tristate;
    logic       battery_connect, seal_released;
    logic [2:0] state;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    supply_guard #(.CLK_KHZ(200000), .RECOVERY_US(1)) i_supply_guard (
        .clk              (clk),
        .rst_n            (rst_n),
        .supply_code      (supply_code),
        .tol_sel_wide     (tol_sel_wide),
        .ce_n             (ce_n),
        .access_enable    (access_enable),
        .write_protect    (write_protect),
        .outputs_tristate (outputs_tristate),
        .battery_connect  (battery_connect),
        .seal_released    (seal_released),
        .state            (state)
    );

    // {wide, ce_n, code, expected state}
    localparam int NV = 14;
    localparam logic [14:0] VEC [NV] = '{
        {1'b0, 1'b1, 10'd250, 3'd0},
        {1'b0, 1'b1, 10'd425, 3'd0},
        {1'b0, 1'b1, 10'd426, 3'd2},
        {1'b0, 1'b1, 10'd299, 3'd2},
        {1'b0, 1'b1, 10'd298, 3'd3},
        {1'b0, 1'b1, 10'd301, 3'd3},
        {1'b0, 1'b1, 10'd302, 3'd2},
        {1'b0, 1'b1, 10'd476, 3'd2},
        {1'b0, 1'b1, 10'd477, 3'd4},
        {1'b0, 1'b1, 10'd452, 3'd2},
        {1'b1, 1'b1, 10'd451, 3'd2},
        {1'b1, 1'b1, 10'd452, 3'd4},
        {1'b1, 1'b1, 10'd428, 3'd4},
        {1'b1, 1'b1, 10'd427, 3'd2}
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic hold_no_access(input int n, input string tag);
        int early = 0;
        for (int k = 0; k < n; k++) begin
            step(1);
            if (access_enable) early++;
        end
        check(tag, early, 0);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; supply_code = '0; tol_sel_wide = 1'b0; ce_n = 1'b1;
        step(3);
        check("R5 reset state", state, 0);
        check("R5 reset seal", seal_released, 0);
        check("R5 reset battery", battery_connect, 0);
        check("R3 reset protect", write_protect, 1);
        check("R3 reset tristate", outputs_tristate, 1);
        check("R3 reset access", access_enable, 0);
        rst_n = 1'b1;
        step(1);

        // R9 one step per edge through the table; R1 R2 R4 R5 levels
        for (int i = 0; i < NV; i++) begin
            tol_sel_wide = VEC[i][14];
            ce_n         = VEC[i][13];
            supply_code  = VEC[i][12:3];
            step(1);
            check($sformatf("R9 table %0d state", i), state, VEC[i][2:0]);
            check($sformatf("R4 table %0d battery", i), battery_connect, VEC[i][2:0] == 3'd3);
            check($sformatf("R5 table %0d seal", i), seal_released, i >= 2);
            check($sformatf("R3 table %0d protect", i), write_protect, 1);
        end

        // R7 full recovery window
        tol_sel_wide = 1'b0; supply_code = 10'd500; ce_n = 1'b1;
        step(1);
        check("R1 rise to recovery", state, 4);
        hold_no_access(REC - 1, "R7 early access");
        step(1);
        check("R7 access after window", access_enable, 1);
        check("R3 normal unprotected", write_protect, 0);

        // R3 tristate follows ce_n in NORMAL
        ce_n = 1'b0; #1;
        check("R3 tristate ce low", outputs_tristate, 0);
        ce_n = 1'b1; #1;
        check("R3 tristate ce high", outputs_tristate, 1);

        // R1 narrow fall trip with hysteresis
        supply_code = 10'd453;
        step(1);
        check("R1 453 stays normal", state, 1);
        supply_code = 10'd452; ce_n = 1'b0;
        step(1);
        check("R1 452 protects", state, 2);
        check("R3 ce low still tristate", outputs_tristate, 1);
        check("R3 ce low no access", access_enable, 0);

        // R7 ce_n activity restarts the count
        supply_code = 10'd500;
        step(1);
        check("R7 enter recovery", state, 4);
        hold_no_access(300, "R7 ce low holds off");
        ce_n = 1'b1;
        hold_no_access(100, "R7 partial window");
        ce_n = 1'b0;
        step(1);
        ce_n = 1'b1;
        hold_no_access(REC - 1, "R7 restarted window");
        step(1);
        check("R7 normal after restart", state, 1);

        // R2 wide fall trip from NORMAL
        tol_sel_wide = 1'b1; supply_code = 10'd428;
        step(1);
        check("R2 428 stays normal", state, 1);
        supply_code = 10'd427;
        step(1);
        check("R2 427 protects", state, 2);

        // R8 abort recovery
        tol_sel_wide = 1'b0; supply_code = 10'd500;
        step(1);
        hold_no_access(150, "R8 before abort");
        supply_code = 10'd452;
        step(1);
        check("R8 abort to protect", state, 2);
        supply_code = 10'd500;
        step(1);
        check("R8 reenter recovery", state, 4);
        hold_no_access(REC - 1, "R8 count restarted");
        step(1);
        check("R8 normal after full window", state, 1);

        // R9 single step, R4 battery, R6 seal sticky
        supply_code = 10'd0;
        step(1);
        check("R9 first step protect", state, 2);
        step(1);
        check("R4 battery state", state, 3);
        check("R4 battery connected", battery_connect, 1);
        check("R6 seal kept at zero supply", seal_released, 1);
        supply_code = 10'd301;
        step(1);
        check("R4 301 keeps battery", battery_connect, 1);
        supply_code = 10'd302;
        step(1);
        check("R4 302 releases battery", battery_connect, 0);

        // R5 reset reseals; no battery while sealed
        rst_n = 1'b0;
        step(2);
        check("R5 reset reseals", seal_released, 0);
        rst_n = 1'b1; supply_code = 10'd200;
        step(5);
        check("R5 sealed state kept", state, 0);
        check("R5 sealed no battery", battery_connect, 0);
        supply_code = 10'd426;
        step(1);
        check("R5 release state", state, 2);
        check("R5 release seal", seal_released, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule